// File: doc/BRIEF.md
# Ten-Bit Word Serializer with Clock-Crossing Buffer

This block is the transmit half of a gigabit serial link. A controller in the byte-clock domain presents one 10-bit, already-encoded word per byte-clock period together with a write strobe. The block stores the words in a four-entry buffer that crosses into the bit-clock domain. The bit clock runs at exactly ten times the byte-clock frequency, and the block shifts each word out one bit per bit-clock cycle, starting with bit 0.

The line outputs are a differential pair. In normal operation they carry the serial bit and its complement. Three conditions override them with fixed levels. A transmit reset or a missing PLL lock holds the positive leg low and the negative leg high. Loopback holds both legs high. During loopback, a separate wrap output carries the serial stream so that a local receiver can consume it.

The buffer is elastic. Shifting begins only once two words are waiting. If the buffer runs dry, the last word is sent again and a sticky underflow flag is raised. A word written while the buffer is full is discarded, and a sticky overflow flag is raised.

Top module: `ser10_tx`

## Requirements
- R1: A word on `wr_data` is captured on a rising `byte_clk` edge while `wr_en` is high. Each captured word is sent as 10 consecutive serial bits, bit 0 first and bit 9 last. Words follow one another in capture order with no gap while the buffer holds data.
- R2: Serial output stays idle (`line_p` low) until at least two words are buffered. A single written word alone never starts the stream.
- R3: The buffer holds four words. A word written while four words are buffered is dropped, and `overflow_flag` goes high and stays high until `byte_rst`.
- R4: If no word is buffered when the current word ends, the last word sent is repeated, and `underflow_flag` goes high and stays high until `bit_rst`.
- R5: With lock present, no transmit reset and no loopback, `line_n` is always the complement of `line_p`.
- R6: While `wrap_en` is high (and R7 does not apply), both `line_p` and `line_n` are high, and `wrap_bit` carries the serial stream. While `wrap_en` is low, `wrap_bit` is low.
- R7: While `tx_reset` is high or `pll_locked` is low, `line_p` is low and `line_n` is high. This condition takes priority over loopback.
- R8: After reset, `line_p` is 0, `line_n` is 1, `wrap_bit` is 0 and both flags are 0.
- R9: The first bit of the first word appears on `line_p` within 40 bit-clock periods of the byte-clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byte_clk | input | 1 | Parallel word clock |
| byte_rst | input | 1 | Synchronous active-high reset, byte domain |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 10 | Encoded word, bit 0 sent first |
| overflow_flag | output | 1 | Sticky: a word was dropped on a full buffer |
| bit_clk | input | 1 | Serial clock, ten times `byte_clk` |
| bit_rst | input | 1 | Synchronous active-high reset, bit domain |
| pll_locked | input | 1 | Transmit clock synthesizer has locked |
| tx_reset | input | 1 | Forces the line to its reset level |
| wrap_en | input | 1 | Loopback enable |
| line_p | output | 1 | Positive serial line leg |
| line_n | output | 1 | Negative serial line leg |
| wrap_bit | output | 1 | Serial stream for internal loopback |
| underflow_flag | output | 1 | Sticky: a word was repeated for lack of data |

## Verification
The bench targets the following corner cases.

- **Start threshold.** A single word is written and the line is watched for silence. A design that started on one word would emit it and then fall into repeats.
- **Overflow.** The read side is held in reset while five words arrive. A buffer that accepted the fifth word, or overwrote an older entry, would show that word in the stream that follows.
- **Underflow.** Each stream ends by running the buffer dry. A design that sent zeros or stale entries instead of the last word would break the expected tail.
- **Priority and bit order.** Loopback is combined with transmit reset to check which forced level wins. Distinct asymmetric words expose any reversal of bit order or any slip of word alignment.

// File: rtl/ser10_pkg.sv
package ser10_pkg;

    // Forced-level selection for the line driver
    typedef enum logic [1:0] {
        LINE_DATA = 2'd0,
        LINE_WRAP = 2'd1,
        LINE_HOLD = 2'd2
    } line_mode_e;

    typedef struct packed {
        logic p;
        logic n;
    } line_pair_t;

    localparam int PTR_MAX_W = 8;

    function automatic logic [PTR_MAX_W-1:0] bin_to_gray(input logic [PTR_MAX_W-1:0] b);
        return (b >> 1) ^ b;
    endfunction

    function automatic logic [PTR_MAX_W-1:0] gray_to_bin(input logic [PTR_MAX_W-1:0] g);
        logic [PTR_MAX_W-1:0] b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ser10_afifo.sv
module ser10_afifo
    import ser10_pkg::*;
#(
    parameter int W  = 10,
    parameter int AW = 2
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wen,
    input  logic [W-1:0]  wdata,
    output logic          overflow,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [AW:0]   rlevel
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [W-1:0] mem [DEPTH];

    // write domain
    logic [PW-1:0] wbin, wgray, rq1, rq2, rbin_w, wbin_nx;
    logic [PTR_MAX_W-1:0] rb_conv, wg_nx;
    logic full;

    assign rb_conv = gray_to_bin(PTR_MAX_W'(rq2));
    assign rbin_w  = rb_conv[PW-1:0];
    assign full    = ((wbin - rbin_w) == PW'(DEPTH));
    assign wbin_nx = wbin + PW'(1);
    assign wg_nx   = bin_to_gray(PTR_MAX_W'(wbin_nx));

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else if (wen) begin
            if (full) begin
                overflow <= 1'b1;
            end else begin
                wbin  <= wbin_nx;
                wgray <= wg_nx[PW-1:0];
            end
        end
    end

    always_ff @(posedge wclk) begin
        if (!wrst && wen && !full) begin
            mem[wbin[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            rq1 <= '0;
            rq2 <= '0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
        end
    end

    // read domain
    logic [PW-1:0] rbin, rgray, wq1, wq2, wbin_r, rbin_nx;
    logic [PTR_MAX_W-1:0] wb_conv, rg_nx;

    assign wb_conv = gray_to_bin(PTR_MAX_W'(wq2));
    assign wbin_r  = wb_conv[PW-1:0];
    assign rbin_nx = rbin + PW'(1);
    assign rg_nx   = bin_to_gray(PTR_MAX_W'(rbin_nx));
    assign rlevel  = wbin_r - rbin;
    assign rdata   = mem[rbin[AW-1:0]];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            wq1   <= '0;
            wq2   <= '0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
            if (rd) begin
                rbin  <= rbin_nx;
                rgray <= rg_nx[PW-1:0];
            end
        end
    end

endmodule

// File: rtl/ser10_shifter.sv
module ser10_shifter #(
    parameter int W           = 10,
    parameter int CW          = 3,
    parameter int START_LEVEL = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] level,
    input  logic [W-1:0]  word,
    output logic          pop,
    output logic          sbit,
    output logic          underflow
);
    localparam int BW = $clog2(W);

    logic [W-1:0]  sh_q, last_q;
    logic [BW-1:0] cnt_q;
    logic          run_q, at_end, have_word;

    assign at_end    = (cnt_q == BW'(W - 1));
    assign have_word = (level != '0);
    assign pop       = run_q ? (at_end && have_word) : (level >= CW'(START_LEVEL));
    assign sbit      = run_q & sh_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            last_q    <= '0;
            cnt_q     <= '0;
            run_q     <= 1'b0;
            underflow <= 1'b0;
        end else if (!run_q) begin
            if (pop) begin
                sh_q   <= word;
                last_q <= word;
                cnt_q  <= '0;
                run_q  <= 1'b1;
            end
        end else if (at_end) begin
            cnt_q <= '0;
            if (have_word) begin
                sh_q   <= word;
                last_q <= word;
            end else begin
                sh_q      <= last_q;
                underflow <= 1'b1;
            end
        end else begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + BW'(1);
        end
    end

endmodule

// File: rtl/ser10_linectl.sv
module ser10_linectl
    import ser10_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sbit,
    input  logic wrap_en,
    input  logic tx_reset,
    input  logic pll_locked,
    output logic line_p,
    output logic line_n,
    output logic wrap_bit
);
    line_mode_e mode;
    line_pair_t pair_d, pair_q;
    logic       wrap_q;

    always_comb begin
        if (tx_reset || !pll_locked) mode = LINE_HOLD;
        else if (wrap_en)            mode = LINE_WRAP;
        else                         mode = LINE_DATA;
    end

    always_comb begin
        unique case (mode)
            LINE_HOLD: pair_d = '{p: 1'b0, n: 1'b1};
            LINE_WRAP: pair_d = '{p: 1'b1, n: 1'b1};
            default:   pair_d = '{p: sbit, n: ~sbit};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '{p: 1'b0, n: 1'b1};
            wrap_q <= 1'b0;
        end else begin
            pair_q <= pair_d;
            wrap_q <= wrap_en & sbit;
        end
    end

    assign line_p   = pair_q.p;
    assign line_n   = pair_q.n;
    assign wrap_bit = wrap_q;

endmodule

// File: rtl/ser10_tx.sv
module ser10_tx
    import ser10_pkg::*;
#(
    parameter int WORD_W      = 10,
    parameter int FIFO_AW     = 2,
    parameter int START_LEVEL = 2
) (
    input  logic              byte_clk,
    input  logic              byte_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              overflow_flag,
    input  logic              bit_clk,
    input  logic              bit_rst,
    input  logic              pll_locked,
    input  logic              tx_reset,
    input  logic              wrap_en,
    output logic              line_p,
    output logic              line_n,
    output logic              wrap_bit,
    output logic              underflow_flag
);
    localparam int LVL_W = FIFO_AW + 1;

    logic [WORD_W-1:0] rd_word;
    logic [LVL_W-1:0]  rd_level;
    logic              pop, sbit;

    ser10_afifo #(.W(WORD_W), .AW(FIFO_AW)) fifo_i (
        .wclk     (byte_clk),
        .wrst     (byte_rst),
        .wen      (wr_en),
        .wdata    (wr_data),
        .overflow (overflow_flag),
        .rclk     (bit_clk),
        .rrst     (bit_rst),
        .rd       (pop),
        .rdata    (rd_word),
        .rlevel   (rd_level)
    );

    ser10_shifter #(.W(WORD_W), .CW(LVL_W), .START_LEVEL(START_LEVEL)) shift_i (
        .clk       (bit_clk),
        .rst       (bit_rst),
        .level     (rd_level),
        .word      (rd_word),
        .pop       (pop),
        .sbit      (sbit),
        .underflow (underflow_flag)
    );

    ser10_linectl line_i (
        .clk        (bit_clk),
        .rst        (bit_rst),
        .sbit       (sbit),
        .wrap_en    (wrap_en),
        .tx_reset   (tx_reset),
        .pll_locked (pll_locked),
        .line_p     (line_p),
        .line_n     (line_n),
        .wrap_bit   (wrap_bit)
    );

endmodule

// File: rtl/ser10_tx_chk.sv
module ser10_tx_chk (
    input logic byte_clk,
    input logic byte_rst,
    input logic bit_clk,
    input logic bit_rst,
    input logic pll_locked,
    input logic tx_reset,
    input logic wrap_en,
    input logic line_p,
    input logic line_n,
    input logic wrap_bit,
    input logic underflow_flag,
    input logic overflow_flag
);
    AST_HOLD_LEVEL: assert property (@(posedge bit_clk) disable iff (bit_rst)
        (tx_reset || !pll_locked) |=> (!line_p && line_n)); // R7
    AST_WRAP_LEVEL: assert property (@(posedge bit_clk) disable iff (bit_rst)
        (wrap_en && pll_locked && !tx_reset) |=> (line_p && line_n)); // R6
    AST_WRAP_QUIET: assert property (@(posedge bit_clk) disable iff (bit_rst)
        !wrap_en |=> !wrap_bit); // R6
    AST_DIFF_PAIR: assert property (@(posedge bit_clk) disable iff (bit_rst)
        (pll_locked && !tx_reset && !wrap_en) |=> (line_p != line_n)); // R5
    AST_UFL_STICKY: assert property (@(posedge bit_clk) disable iff (bit_rst)
        underflow_flag |=> underflow_flag); // R4
    AST_OVF_STICKY: assert property (@(posedge byte_clk) disable iff (byte_rst)
        overflow_flag |=> overflow_flag); // R3
endmodule

bind ser10_tx ser10_tx_chk chk_i (
    .byte_clk       (byte_clk),
    .byte_rst       (byte_rst),
    .bit_clk        (bit_clk),
    .bit_rst        (bit_rst),
    .pll_locked     (pll_locked),
    .tx_reset       (tx_reset),
    .wrap_en        (wrap_en),
    .line_p         (line_p),
    .line_n         (line_n),
    .wrap_bit       (wrap_bit),
    .underflow_flag (underflow_flag),
    .overflow_flag  (overflow_flag)
);

// File: tb/ser10_tx_tb.sv
module ser10_tx_tb_top;
    localparam int CAPN = 256;
    localparam int EXPN = 200;

    logic       byte_clk = 1'b0, bit_clk = 1'b0;
    logic       byte_rst = 1'b1, bit_rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic       pll_locked = 1'b0, tx_reset = 1'b0, wrap_en = 1'b0;
    logic       overflow_flag, underflow_flag, line_p, line_n, wrap_bit;

    int n_tests = 0, n_fail = 0;

    always #4 bit_clk = ~bit_clk;
    initial begin
        #2;
        forever #40 byte_clk = ~byte_clk;
    end

    ser10_tx dut_i (
        .byte_clk(byte_clk), .byte_rst(byte_rst), .wr_en(wr_en), .wr_data(wr_data),
        .overflow_flag(overflow_flag), .bit_clk(bit_clk), .bit_rst(bit_rst),
        .pll_locked(pll_locked), .tx_reset(tx_reset), .wrap_en(wrap_en),
        .line_p(line_p), .line_n(line_n), .wrap_bit(wrap_bit),
        .underflow_flag(underflow_flag)
    );

    // capture of line and wrap bits
    logic            cap_on = 1'b0, cap_clr = 1'b0;
    int              cap_n = 0;
    logic [CAPN-1:0] cap_p, cap_nn, cap_w;

    always @(negedge bit_clk) begin
        if (cap_clr) cap_n <= 0;
        else if (cap_on && cap_n < CAPN) begin
            cap_p[cap_n]  <= line_p;
            cap_nn[cap_n] <= line_n;
            cap_w[cap_n]  <= wrap_bit;
            cap_n         <= cap_n + 1;
        end
    end

    logic [9:0]      wq [16];
    int              nw;
    logic [EXPN-1:0] exp_bits;
    int              exp_len;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        byte_rst = 1'b1; bit_rst = 1'b1; cap_on = 1'b0; cap_clr = 1'b1;
        wr_en = 1'b0;
        repeat (3) @(negedge byte_clk);
        cap_clr = 1'b0;
        byte_rst = 1'b0; bit_rst = 1'b0;
    endtask

    task automatic push_words(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge byte_clk);
            wr_en = 1'b1; wr_data = wq[i];
        end
        @(negedge byte_clk);
        wr_en = 1'b0;
    endtask

    // expected stream: the sent words then the last one twice more
    task automatic build_exp(input int sent);
        exp_len = 0;
        for (int i = 0; i < sent + 2; i++) begin
            for (int b = 0; b < 10; b++) begin
                exp_bits[exp_len] = wq[(i < sent) ? i : sent - 1][b];
                exp_len++;
            end
        end
    endtask

    function automatic int find_stream(input logic [CAPN-1:0] bits);
        for (int o = 0; o + exp_len <= CAPN; o++) begin
            logic ok = 1'b1;
            for (int k = 0; k < o; k++) if (bits[k]) ok = 1'b0;
            for (int k = 0; k < exp_len; k++) if (bits[o+k] !== exp_bits[k]) ok = 1'b0;
            if (ok) return o;
        end
        return -1;
    endfunction

    task automatic start_capture();
        cap_clr = 1'b1;
        @(negedge bit_clk);
        cap_clr = 1'b0;
        cap_on = 1'b1;
    endtask

    task automatic wait_capture();
        wait (cap_n == CAPN);
        cap_on = 1'b0;
    endtask

    task automatic t_reset_state();
        byte_rst = 1'b1; bit_rst = 1'b1;
        repeat (3) @(negedge byte_clk);
        check(line_p == 1'b0 && line_n == 1'b1, "R8 line after reset", {line_p, line_n}, 2'b01);
        check(wrap_bit == 1'b0, "R8 wrap_bit after reset", wrap_bit, 0);
        check(!overflow_flag && !underflow_flag, "R8 flags after reset",
              {overflow_flag, underflow_flag}, 0);
    endtask

    task automatic t_unlocked();
        do_reset();
        pll_locked = 1'b0;
        wq[0] = 10'h2B5; wq[1] = 10'h0F0; wq[2] = 10'h3FF; wq[3] = 10'h155;
        start_capture();
        push_words(4);
        wait_capture();
        check(cap_p == '0, "R7 unlocked positive leg low", int'(cap_p[31:0]), 0);
        check(cap_nn == '1, "R7 unlocked negative leg high", int'(cap_nn[31:0]), 32'hFFFFFFFF);
    endtask

    task automatic t_reset_over_wrap();
        do_reset();
        pll_locked = 1'b1; tx_reset = 1'b1; wrap_en = 1'b1;
        wq[0] = 10'h3FF; wq[1] = 10'h3FF; wq[2] = 10'h3FF;
        start_capture();
        push_words(3);
        wait_capture();
        check(cap_p == '0 && cap_nn == '1, "R7 tx_reset dominates wrap",
              int'({cap_p[15:0], cap_nn[15:0]}), 32'h0000FFFF);
        tx_reset = 1'b0; wrap_en = 1'b0;
    endtask

    task automatic t_single_word();
        do_reset();
        pll_locked = 1'b1;
        wq[0] = 10'h3FF;
        start_capture();
        push_words(1);
        wait_capture();
        check(cap_p == '0, "R2 one word must not start stream", int'(cap_p[31:0]), 0);
        check(!underflow_flag, "R2 no repeat without start", underflow_flag, 0);
    endtask

    task automatic t_stream(input int cnt, input string tag);
        int off;
        do_reset();
        pll_locked = 1'b1;
        start_capture();
        push_words(cnt);
        wait_capture();
        build_exp(cnt);
        off = find_stream(cap_p);
        check(off >= 0, {"R1 serial order ", tag}, off, 0);
        check(off >= 0 && off < 40, {"R9 first bit latency ", tag}, off, 39);
        check((cap_nn ^ cap_p) == '1, {"R5 complementary legs ", tag},
              int'(cap_nn[31:0] ^ cap_p[31:0]), 32'hFFFFFFFF);
        check(cap_w == '0, {"R6 wrap_bit quiet ", tag}, int'(cap_w[31:0]), 0);
        check(underflow_flag == 1'b1, {"R4 underflow flag ", tag}, underflow_flag, 1);
        check(overflow_flag == 1'b0, {"R3 no overflow ", tag}, overflow_flag, 0);
    endtask

    task automatic t_overflow();
        int off;
        do_reset();
        pll_locked = 1'b1;
        bit_rst = 1'b1;
        wq[0] = 10'h0C3; wq[1] = 10'h1E0; wq[2] = 10'h2AA; wq[3] = 10'h30F; wq[4] = 10'h3FF;
        push_words(5);
        @(negedge byte_clk);
        check(overflow_flag == 1'b1, "R3 overflow flag on fifth word", overflow_flag, 1);
        start_capture();
        bit_rst = 1'b0;
        wait_capture();
        build_exp(4);
        off = find_stream(cap_p);
        check(off >= 0, "R3 dropped word absent, four kept", off, 0);
        check(overflow_flag == 1'b1, "R3 overflow flag sticky", overflow_flag, 1);
    endtask

    task automatic t_wrap();
        int off;
        do_reset();
        pll_locked = 1'b1; wrap_en = 1'b1;
        wq[0] = 10'h1A7; wq[1] = 10'h058; wq[2] = 10'h2E3; wq[3] = 10'h11C;
        start_capture();
        push_words(4);
        wait_capture();
        build_exp(4);
        off = find_stream(cap_w);
        check(off >= 0, "R6 wrap_bit carries stream", off, 0);
        check(cap_p == '1 && cap_nn == '1, "R6 both legs high in wrap",
              int'({cap_p[15:0], cap_nn[15:0]}), 32'hFFFFFFFF);
        wrap_en = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_unlocked();
        t_reset_over_wrap();
        t_single_word();
        wq[0] = 10'h2B5; wq[1] = 10'h0F0; wq[2] = 10'h3FF; wq[3] = 10'h001; wq[4] = 10'h156;
        t_stream(5, "A");
        wq[0] = 10'h155; wq[1] = 10'h2AA; wq[2] = 10'h3E0; wq[3] = 10'h01F;
        wq[4] = 10'h200; wq[5] = 10'h001; wq[6] = 10'h33C; wq[7] = 10'h0C3;
        t_stream(8, "B");
        t_overflow();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule